// File: doc/BRIEF.md
# Four-Channel Stuck-Dominant Guard

This block sits in front of the routing logic of a two-bus CAN transceiver. It watches four active-low logic signals: the local transmit input, the expansion transmit input and the received data of each of the two buses. Each signal passes through a channel of its own. A channel passes its input through unchanged until the input has been dominant (low) for a set number of clock cycles. After that it forces its output recessive (high) and raises a per-channel flag. The flag clears and the output follows the input again once the input itself returns recessive. Because of this, one transmitter or one bus that sticks at dominant cannot hold both buses dominant for good.

All channels share one timeout limit, a parameter counted in clock cycles, and each keeps its own counter. The power-on reset is asynchronous and active low. Its release is synchronised inside the block. While reset is held, every counter and flag stays cleared and the outputs simply follow the inputs.

Top module: `dom_guard_quad`

## Requirements
- R1: While power-on reset is asserted, every timeout flag is 0, no channel forces its output, and each output equals its input.
- R2: A channel that has not timed out drives its output equal to its input within the same cycle, with no register in the path.
- R3: Bit positions are 0 for the local transmit input, 1 for the expansion transmit input, 2 for bus 1 receive and 3 for bus 2 receive. When a channel's input has been sampled low on LIMIT_CYC consecutive rising edges, its flag becomes 1 and its output becomes 1 after the LIMIT_CYC-th edge. After LIMIT_CYC-1 low samples the output is still low.
- R4: Once timed out, a channel keeps its flag at 1 and its output at 1 for as long as its input stays low.
- R5: The first rising edge that samples a timed-out channel's input high clears the flag. A later dominant period is then timed from zero and again needs the full LIMIT_CYC samples.
- R6: Any single high sample restarts the count, so dominant runs shorter than LIMIT_CYC separated by single recessive cycles never cause a timeout.
- R7: The four channels are independent. The count, timeout or recovery of one channel has no effect on the output or flag of any other channel.
- R8: Asserting reset clears all flags at once, without waiting for a clock edge. After reset is released, two rising edges pass before counting starts, so an input held low across the release times out on the (2+LIMIT_CYC)-th edge after the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| dom_in_n | input | 4 | Active-low signals under watch, one bit per channel |
| dom_out_n | output | 4 | Guarded signals sent to the routing logic |
| tmo_flag | output | 4 | High while the matching channel is forcing recessive |

## Verification
A vector walk drives all four channels at once with different patterns. One channel holds a long low run that times out, recovers and then times out again. One sends runs of LIMIT_CYC-1 lows split by single highs. One stays recessive. One starts its timeout late and recovers while another is still timed out. Together these separate a channel that counts total low time from one that counts consecutive low samples, an off-by-one in the limit, a flag that clears late or not at all, and crosstalk between channels. Directed tests then check that the output tracks an input change between clock edges, that reset clears the flags without a clock edge, and the exact edge on which counting resumes after reset is released.

// File: rtl/dg_pkg.sv
package dg_pkg;
  // Number of guarded signals and their bit positions on the ports
  localparam int unsigned DG_CH_N       = 4;
  localparam int unsigned DG_IDX_TX_LOC = 0;
  localparam int unsigned DG_IDX_TX_EXP = 1;
  localparam int unsigned DG_IDX_RX_B1  = 2;
  localparam int unsigned DG_IDX_RX_B2  = 3;
endpackage

// File: rtl/dg_rst_sync.sv
module dg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sync_n
);
  localparam int unsigned SW = (STAGES < 2) ? 2 : STAGES;

  logic [SW-1:0] sh_q;
  logic [SW-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[SW-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[SW-1];

  // R8: the synchronised reset only rises while the raw reset is released
  release_after_raw_chk: assert property (@(posedge clk)
    $rose(rst_sync_n) |-> arst_n);
endmodule

// File: rtl/dg_chan.sv
module dg_chan #(
  parameter int unsigned LIMIT_CYC = 4000,
  parameter int unsigned CNT_W     = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_n,
  output logic guard_n,
  output logic tmo
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT_CYC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             to_q, to_d;
  logic             upd_en;

  // next state
  always_comb begin
    cnt_d  = cnt_q;
    to_d   = to_q;
    upd_en = 1'b0;
    if (sig_n) begin
      cnt_d  = '0;
      to_d   = 1'b0;
      upd_en = to_q || (cnt_q != '0);
    end else if (!to_q) begin
      upd_en = 1'b1;
      if (cnt_q == LAST) to_d = 1'b1;
      else               cnt_d = cnt_q + 1'b1;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      to_q  <= 1'b0;
    end else if (upd_en) begin
      cnt_q <= cnt_d;
      to_q  <= to_d;
    end
  end

  assign guard_n = sig_n | to_q;
  assign tmo     = to_q;

  // R3
  tmo_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(to_q) |-> ($past(!sig_n) && ($past(cnt_q) == LAST)));
  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  // R4
  tmo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (to_q && !sig_n) |=> to_q);
  // R5
  tmo_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (to_q && sig_n) |=> (!to_q && (cnt_q == '0)));
  // R6
  cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sig_n |=> (cnt_q == '0));
endmodule

// File: rtl/dom_guard_quad.sv
module dom_guard_quad
  import dg_pkg::*;
#(
  parameter int unsigned LIMIT_CYC   = 4000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic [DG_CH_N-1:0] dom_in_n,
  output logic [DG_CH_N-1:0] dom_out_n,
  output logic [DG_CH_N-1:0] tmo_flag
);
  localparam int unsigned LIM   = (LIMIT_CYC < 1) ? 1 : LIMIT_CYC;
  localparam int unsigned CNT_W = $clog2(LIM + 1);

  logic rst_n;

  dg_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .arst_n     (por_n),
    .rst_sync_n (rst_n)
  );

  for (genvar gi = 0; gi < DG_CH_N; gi++) begin : g_ch
    dg_chan #(.LIMIT_CYC(LIM), .CNT_W(CNT_W)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .sig_n   (dom_in_n[gi]),
      .guard_n (dom_out_n[gi]),
      .tmo     (tmo_flag[gi])
    );
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !por_n |-> (tmo_flag == '0));
endmodule

// File: tb/sim_dom_guard_quad.sv
module sim_dom_guard_quad;
  import dg_pkg::*;

  localparam int unsigned LIM = 4;

  logic       clk;
  logic       por_n;
  logic [3:0] din;
  logic [3:0] dout;
  logic [3:0] tmo;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  dom_guard_quad #(.LIMIT_CYC(LIM), .SYNC_STAGES(2)) u0 (
    .clk       (clk),
    .por_n     (por_n),
    .dom_in_n  (din),
    .dom_out_n (dout),
    .tmo_flag  (tmo)
  );

  // {input, expected output, expected flags}, one vector per clock
  localparam logic [11:0] VEC [0:11] = '{
    12'b1100_1100_0000,
    12'b1100_1100_0000,
    12'b0100_0100_0000,
    12'b0110_0111_0001,
    12'b0100_0101_0001,
    12'b0100_1101_1001,
    12'b0101_1101_1000,
    12'b1110_1110_0000,
    12'b1100_1100_0000,
    12'b0100_0100_0000,
    12'b0100_0101_0001,
    12'b0111_0111_0000
  };

  initial begin
    clk = 1'b0;
    forever #5 clk = ~clk;
  end

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got hung expected finished");
    finish_run();
  end

  initial begin
    por_n = 1'b0;
    din   = 4'hF;
    repeat (3) @(negedge clk);
    // R1: flags clear, outputs follow inputs during reset
    chk("R1 flags in reset", tmo, 4'h0);
    chk("R1 output in reset", dout, 4'hF);
    din = 4'h0;
    repeat (6) @(negedge clk);
    chk("R1 no forcing in reset", dout, 4'h0);
    chk("R1 flags stay low", tmo, 4'h0);
    din = 4'hF;
    @(negedge clk);
    por_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 R3 R4 R5 R6 R7: vector walk, tx_loc/tx_exp/rx_b1/rx_b2 on bits 0..3
    for (int i = 0; i < 12; i++) begin
      din = VEC[i][11:8];
      @(negedge clk);
      chk($sformatf("R3 R4 R5 R6 R7 output step %0d", i), dout, VEC[i][7:4]);
      chk($sformatf("R3 R4 R5 R6 R7 flags step %0d", i), tmo, VEC[i][3:0]);
    end

    // R2: output tracks input between clock edges
    din = 4'hF;
    @(negedge clk);
    #2 din = 4'b1010;
    #1 chk("R2 combinational pass", dout, 4'b1010);
    din = 4'hF;
    @(negedge clk);

    // R3: every channel times out together
    din = 4'h0;
    repeat (4) @(negedge clk);
    chk("R3 all flags", tmo, 4'hF);
    chk("R3 all forced", dout, 4'hF);

    // R8: reset clears flags without a clock edge
    #2 por_n = 1'b0;
    #1 chk("R8 async clear flags", tmo, 4'h0);
    chk("R8 async clear output", dout, 4'h0);
    @(negedge clk);
    por_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R8 not yet timed out", tmo, 4'h0);
    @(negedge clk);
    chk("R8 timeout on edge 2+LIM", tmo, 4'hF);

    din = 4'hF;
    @(negedge clk);
    chk("R5 recovered", tmo, 4'h0);
    finish_run();
  end
endmodule